// File: doc/BRIEF.md
# Boot Retry Supervisor

This block lives in the fallback configuration of a device whose non-volatile storage holds exactly two configurations: a fallback image and an application image. Each time the fallback image starts, the supervisor first asks the reconfiguration controller why it is running. If an application load failed, it reads a persistent retry byte from storage, adds one, and stores the new value. If the load did not fail, it stores zero instead. If the stored value is still below a compile-time limit, it fires a reconfiguration into the application image.

Each failed application load brings the device back to the fallback image, so the sequence runs again on every failure. After a set number of failures the supervisor stops retrying. It then parks and waits for a host to report that a fresh application image has been written. When that report arrives, it clears the stored count and tries the new image once.

The status query, the storage byte access and the reconfiguration request are modelled as simple handshakes. The real flash protocol and the configuration hardware are outside the block.

Top module: `boot_retry_supervisor`

## Requirements
- R1: After reset is released the block waits one cycle. It then raises `stat_req` and holds it until `stat_valid` is seen. No storage access and no trigger happens before the status answer. While reset is asserted every output is 0.
- R2: If the status reports an error (`stat_err`=1 with `stat_valid`), the block raises `nv_rd_req` until `nv_done`. It then writes back the byte read plus one on `nv_wdata` with `nv_wr_req`.
- R3: The count saturates at 255 (all ones for `CNT_W`=8). A stored 255 is written back as 255 and never wraps to 0.
- R4: If the status reports no error, the block does not read storage. It writes 0 and then continues as after any write.
- R5: When a write completes (`nv_done` while `nv_wr_req`) and the written count is below `THRESHOLD`, `cfg_trigger` is high for exactly one cycle, in the cycle after the write completes. After that, all requests stay low until the next reset.
- R6: When a write completes and the written count is at or above `THRESHOLD`, no trigger is issued. `halted` goes high in the next cycle and stays high.
- R7: A `host_new_image` pulse while `halted` is high drops `halted`, writes 0 to storage, and then issues one trigger as in R5.
- R8: A `host_new_image` pulse while `halted` is low has no effect. This includes a pulse in the same cycle as the write completion that leads to `halted`.
- R9: `retry_count` always shows the working count. `nv_wdata` equals `retry_count` while `nv_wr_req` is high.
- R10: At most one of `stat_req`, `nv_rd_req`, `nv_wr_req` and `cfg_trigger` is high in any cycle. A storage request stays high until `nv_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stat_req | output | 1 | Request for the reconfiguration-cause status |
| stat_valid | input | 1 | Status answer is valid this cycle |
| stat_err | input | 1 | The last application load failed (read with `stat_valid`) |
| nv_rd_req | output | 1 | Read request for the stored retry byte |
| nv_wr_req | output | 1 | Write request for the stored retry byte |
| nv_wdata | output | CNT_W | Byte to be written |
| nv_rdata | input | CNT_W | Byte read (sampled with `nv_done`) |
| nv_done | input | 1 | The pending storage access completes this cycle |
| cfg_trigger | output | 1 | One-cycle request to load the application image |
| host_new_image | input | 1 | Host pulse: a new application image was stored |
| halted | output | 1 | Retries are used up; waiting for the host |
| retry_count | output | CNT_W | Working retry count |

## Verification
Two events can fall in the same cycle: the write completion that ends the retry budget, and the host's new-image pulse. The bench's storage responder can raise `host_new_image` in exactly the cycle it raises `nv_done` for that write. The pulse arrives one cycle before `halted` is high, so it must be dropped. The reference model and the final checks expect the block to stay halted, with the stored count unchanged and no trigger. Host pulses during the read phase are also provoked, to show they are ignored before the block halts.

// File: rtl/brs_pkg.sv
package brs_pkg;

  typedef enum logic [2:0] {
    SQ_BOOT     = 3'd0,
    SQ_STATUS   = 3'd1,
    SQ_FETCH    = 3'd2,
    SQ_BUMP     = 3'd3,
    SQ_STORE    = 3'd4,
    SQ_FIRE     = 3'd5,
    SQ_PARK     = 3'd6,
    SQ_LAUNCHED = 3'd7
  } sq_state_e;

endpackage

// File: rtl/brs_count_unit.sv
module brs_count_unit #(
  parameter int CNT_W     = 8,
  parameter int THRESHOLD = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             bump,
  input  logic             clear,
  output logic [CNT_W-1:0] count,
  output logic             at_limit
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] LIMIT   = CNT_W'(THRESHOLD);

  // saturating increment
  function automatic logic [CNT_W-1:0] sat_bump(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + CNT_ONE;
  endfunction

  function automatic logic limit_hit(input logic [CNT_W-1:0] v);
    return v >= LIMIT;
  endfunction

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count_q <= '0;
    else if (clear) count_q <= '0;
    else if (load)  count_q <= load_val;
    else if (bump)  count_q <= sat_bump(count_q);
  end

  assign count    = count_q;
  assign at_limit = limit_hit(count_q);

  // R3: no wrap at the top
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && !clear && !load && count_q == CNT_MAX) |=> count_q == CNT_MAX);

  // R2: increment by one below the top
  p_bump_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && !clear && !load && count_q != CNT_MAX) |=> count_q == $past(count_q) + CNT_ONE);

  // R4 / R7: clear gives zero
  p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> count_q == '0);

  // R9: loaded byte becomes the working count
  p_load_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear) |=> count_q == $past(load_val));

endmodule

// File: rtl/brs_sequencer.sv
module brs_sequencer
  import brs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stat_valid,
  input  logic stat_err,
  input  logic nv_done,
  input  logic host_new_image,
  input  logic at_limit,
  output logic stat_req,
  output logic nv_rd_req,
  output logic nv_wr_req,
  output logic cfg_trigger,
  output logic halted,
  output logic cnt_load,
  output logic cnt_bump,
  output logic cnt_clear
);

  sq_state_e state_q, state_d;

  // named internal events
  logic ev_status_ok, ev_status_bad, ev_read_done, ev_write_done, ev_host_go;

  assign ev_status_ok  = (state_q == SQ_STATUS) && stat_valid && !stat_err;
  assign ev_status_bad = (state_q == SQ_STATUS) && stat_valid &&  stat_err;
  assign ev_read_done  = (state_q == SQ_FETCH)  && nv_done;
  assign ev_write_done = (state_q == SQ_STORE)  && nv_done;
  assign ev_host_go    = (state_q == SQ_PARK)   && host_new_image;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_BOOT:     state_d = SQ_STATUS;
      SQ_STATUS:   if (ev_status_bad) state_d = SQ_FETCH;
                   else if (ev_status_ok) state_d = SQ_STORE;
      SQ_FETCH:    if (ev_read_done) state_d = SQ_BUMP;
      SQ_BUMP:     state_d = SQ_STORE;
      SQ_STORE:    if (ev_write_done) state_d = at_limit ? SQ_PARK : SQ_FIRE;
      SQ_FIRE:     state_d = SQ_LAUNCHED;
      SQ_PARK:     if (ev_host_go) state_d = SQ_STORE;
      SQ_LAUNCHED: state_d = SQ_LAUNCHED;
      default:     state_d = SQ_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_BOOT;
    else        state_q <= state_d;
  end

  assign stat_req    = (state_q == SQ_STATUS);
  assign nv_rd_req   = (state_q == SQ_FETCH);
  assign nv_wr_req   = (state_q == SQ_STORE);
  assign cfg_trigger = (state_q == SQ_FIRE);
  assign halted      = (state_q == SQ_PARK);
  assign cnt_load    = ev_read_done;
  assign cnt_bump    = (state_q == SQ_BUMP);
  assign cnt_clear   = ev_status_ok || ev_host_go;

  // R10: one request at a time
  p_single_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stat_req, nv_rd_req, nv_wr_req, cfg_trigger}));

  // R10: storage requests held until done
  p_hold_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_rd_req && !nv_done) |=> nv_rd_req);
  p_hold_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_wr_req && !nv_done) |=> nv_wr_req);

  // R5: trigger is a single pulse following a completed write below the limit
  p_trig_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_trigger |=> !cfg_trigger);
  p_trig_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_trigger |-> $past(nv_wr_req && nv_done && !at_limit));

  // R6: halting follows a completed write at the limit, never with a trigger
  p_halt_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> $past(nv_wr_req && nv_done && at_limit));
  p_halt_no_trig_r6: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !cfg_trigger);

  // R1: the status request does not stay high after its answer
  p_status_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_req && stat_valid) |=> !stat_req);

endmodule

// File: rtl/boot_retry_supervisor.sv
module boot_retry_supervisor #(
  parameter int CNT_W     = 8,
  parameter int THRESHOLD = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             stat_req,
  input  logic             stat_valid,
  input  logic             stat_err,
  output logic             nv_rd_req,
  output logic             nv_wr_req,
  output logic [CNT_W-1:0] nv_wdata,
  input  logic [CNT_W-1:0] nv_rdata,
  input  logic             nv_done,
  output logic             cfg_trigger,
  input  logic             host_new_image,
  output logic             halted,
  output logic [CNT_W-1:0] retry_count
);

  logic             w_load, w_bump, w_clear, w_at_limit;
  logic [CNT_W-1:0] w_count;

  brs_sequencer u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .stat_valid     (stat_valid),
    .stat_err       (stat_err),
    .nv_done        (nv_done),
    .host_new_image (host_new_image),
    .at_limit       (w_at_limit),
    .stat_req       (stat_req),
    .nv_rd_req      (nv_rd_req),
    .nv_wr_req      (nv_wr_req),
    .cfg_trigger    (cfg_trigger),
    .halted         (halted),
    .cnt_load       (w_load),
    .cnt_bump       (w_bump),
    .cnt_clear      (w_clear)
  );

  brs_count_unit #(.CNT_W(CNT_W), .THRESHOLD(THRESHOLD)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (w_load),
    .load_val (nv_rdata),
    .bump     (w_bump),
    .clear    (w_clear),
    .count    (w_count),
    .at_limit (w_at_limit)
  );

  assign nv_wdata    = w_count;
  assign retry_count = w_count;

  // R9: write data is the working count
  p_wdata_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nv_wr_req |-> nv_wdata == retry_count);

endmodule

// File: tb/tb_boot_retry_supervisor.sv
module tb_boot_retry_supervisor;

  localparam int THR = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stat_valid = 1'b0, stat_err = 1'b0, nv_done = 1'b0, host_new_image = 1'b0;
  logic stat_req, nv_rd_req, nv_wr_req, cfg_trigger, halted;
  logic [7:0] nv_wdata, retry_count, nv_rdata;

  always #10 clk = ~clk; // 50 MHz

  int checks = 0, errors = 0, cycles = 0;

  // storage and responders
  int mem = 0;
  int sc_err = 0, st_lat = 0, nv_lat = 0, st_ctr = 0, nv_ctr = 0;
  bit host_fire = 0, coincide = 0;
  int trig_cnt = 0;
  assign nv_rdata = mem[7:0];

  boot_retry_supervisor dut (
    .clk(clk), .rst_n(rst_n), .stat_req(stat_req), .stat_valid(stat_valid),
    .stat_err(stat_err), .nv_rd_req(nv_rd_req), .nv_wr_req(nv_wr_req),
    .nv_wdata(nv_wdata), .nv_rdata(nv_rdata), .nv_done(nv_done),
    .cfg_trigger(cfg_trigger), .host_new_image(host_new_image),
    .halted(halted), .retry_count(retry_count)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase codes and a remembered count
  int m_phase = 0, m_cnt = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_phase <= 0; m_cnt <= 0; end
    else begin
      if (m_phase == 0) m_phase <= 1;
      else if (m_phase == 1 && stat_valid) begin
        if (stat_err) m_phase <= 2;
        else begin m_cnt <= 0; m_phase <= 4; end
      end
      else if (m_phase == 2 && nv_done) begin m_cnt <= int'(nv_rdata); m_phase <= 3; end
      else if (m_phase == 3) begin m_cnt <= (m_cnt >= 255) ? 255 : m_cnt + 1; m_phase <= 4; end
      else if (m_phase == 4 && nv_done) m_phase <= (m_cnt >= THR) ? 6 : 5;
      else if (m_phase == 5) m_phase <= 7;
      else if (m_phase == 6 && host_new_image) begin m_cnt <= 0; m_phase <= 4; end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(stat_req == (m_phase == 1), "R1 stat_req", stat_req, m_phase == 1);
      check(nv_rd_req == (m_phase == 2), "R2 nv_rd_req", nv_rd_req, m_phase == 2);
      check(nv_wr_req == (m_phase == 4), "R4 nv_wr_req", nv_wr_req, m_phase == 4);
      check(cfg_trigger == (m_phase == 5), "R5 cfg_trigger", cfg_trigger, m_phase == 5);
      check(halted == (m_phase == 6), "R6 halted", halted, m_phase == 6);
      check(int'(retry_count) == m_cnt, "R9 retry_count", retry_count, m_cnt);
      if (nv_wr_req) check(int'(nv_wdata) == m_cnt, "R9 nv_wdata", nv_wdata, m_cnt);
      if (cfg_trigger) trig_cnt++;
    end
  end

  // responders, driven on the falling edge
  always @(negedge clk) begin
    host_new_image = 1'b0;
    if (host_fire) begin host_new_image = 1'b1; host_fire = 0; end
    if (stat_valid) begin stat_valid = 1'b0; st_ctr = 0; end
    else if (stat_req) begin
      if (st_ctr >= st_lat) begin stat_valid = 1'b1; stat_err = sc_err[0]; end
      else st_ctr++;
    end else st_ctr = 0;
    if (nv_done) begin nv_done = 1'b0; nv_ctr = 0; end
    else if (nv_rd_req || nv_wr_req) begin
      if (nv_ctr >= nv_lat) begin
        nv_done = 1'b1;
        if (nv_wr_req) begin
          mem = int'(nv_wdata);
          if (coincide) host_new_image = 1'b1;
        end
      end else nv_ctr++;
    end else nv_ctr = 0;
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic boot(input int err, input int memv, input int sl, input int nl,
                      input bit early_host, input bit late_host, input bit coin);
    @(negedge clk);
    rst_n = 1'b0;
    stat_valid = 1'b0; nv_done = 1'b0; st_ctr = 0; nv_ctr = 0;
    sc_err = err; mem = memv; st_lat = sl; nv_lat = nl; coincide = coin;
    repeat (3) @(negedge clk);
    check(!stat_req && !nv_rd_req && !nv_wr_req && !cfg_trigger && !halted && retry_count == 0,
          "R1 reset outputs", {stat_req, nv_rd_req, nv_wr_req, cfg_trigger, halted}, 0);
    trig_cnt = 0;
    rst_n = 1'b1;
    if (early_host) begin
      while (m_phase != 2) @(negedge clk);
      host_fire = 1;
    end
    while (!(m_phase == 6 || m_phase == 7)) @(negedge clk);
    if (late_host && m_phase == 6) begin
      repeat (3) @(negedge clk);
      host_fire = 1;
      while (m_phase != 7) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    coincide = 0;
  endtask

  initial begin
    // R4: good boot clears stale count
    boot(0, 5, 1, 2, 0, 0, 0);
    check(mem == 0, "R4 stored", mem, 0);
    check(trig_cnt == 1, "R5 trigger count", trig_cnt, 1);
    // R2: failed boot increments
    boot(1, 0, 0, 0, 0, 0, 0);
    check(mem == 1, "R2 stored", mem, 1);
    check(trig_cnt == 1, "R5 trigger count", trig_cnt, 1);
    boot(1, 1, 2, 3, 0, 0, 0);
    check(mem == 2, "R2 stored", mem, 2);
    // R6 then R7, with an early host pulse for R8
    boot(1, 2, 1, 1, 1, 1, 0);
    check(mem == 0, "R7 stored after host", mem, 0);
    check(trig_cnt == 1, "R7 trigger count", trig_cnt, 1);
    check(!halted, "R7 halted low", halted, 0);
    // R3: saturation
    boot(1, 255, 0, 1, 0, 0, 0);
    check(mem == 255, "R3 stored", mem, 255);
    check(halted, "R6 halted", halted, 1);
    check(trig_cnt == 0, "R6 no trigger", trig_cnt, 0);
    // R8: host pulse coinciding with the halting write completion
    boot(1, 2, 0, 2, 0, 0, 1);
    check(halted, "R8 still halted", halted, 1);
    check(mem == 3, "R8 stored", mem, 3);
    check(trig_cnt == 0, "R8 no trigger", trig_cnt, 0);
    // R6: count read already above the limit
    boot(1, 7, 1, 0, 0, 0, 0);
    check(mem == 8 && halted, "R6 above limit", mem, 8);
    // R10 is covered per cycle by the request comparisons above
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule